// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Probe

This block is the storage and maintenance half of a software-refilled address translation buffer. It keeps a parameterised number of fully associative entries. Each entry maps a pair of adjacent virtual pages, an even one and an odd one, under a variable page size. Software never touches the entries directly. It loads a small set of staging registers: the page-pair tag with its address-space ID, the two per-page physical descriptors, the page-size mask and a slot index. It then issues one-cycle commands that move data between the staging registers and the entry array.

Six commands are supported. Two write an entry: one at the slot selected by the index register, one at a slot supplied by an external pseudo-random source. A probe searches all entries in parallel and returns the lowest matching slot, or a miss flag. A read copies an entry back into the staging registers. Two invalidation commands work on many entries in one cycle: one clears every private mapping of the current address space, the other clears everything. Every command completes on the clock edge that samples it, so no busy indication is needed.

Top module: `soft_tlb`

## Requirements
- R1: After synchronous reset every entry is invalid and all five staging registers read zero.
- R2: With `reg_we` high, the word on `reg_wdata` is stored on the next edge into the staging register chosen by `reg_sel`: 0 tag (bits 31:13 page-pair number, bit 10 invalid flag, bits 7:0 address-space ID), 1 even descriptor, 2 odd descriptor, 3 page mask (bits 28:13), 4 index (bit 31 miss flag).
- R3: Command 1 writes the slot given by index bits 30:0 modulo the entry count. Command 2 writes the slot given by `rand_idx` modulo the entry count.
- R4: A written entry is global only when bit 0 of both descriptors is set. A read returns that global bit in bit 0 of both descriptors.
- R5: A write whose tag has bit 10 set only marks the slot invalid and loads none of its other fields.
- R6: The stored physical frame number (descriptor bits 25:6) has every bit cleared whose matching page-mask bit is set; frame bit k pairs with page-mask bit 13+k.
- R7: Command 3 (probe) hits an entry that is valid, is global or carries the tag's address-space ID, and has a page-pair number equal to the tag's on every bit not covered by the entry's mask. On a hit the index register becomes the lowest hitting slot with bit 31 clear, one edge after the strobe.
- R8: On a probe miss the index register keeps bits 30:0 and gets bit 31 set.
- R9: Command 4 (read) of a valid entry loads the tag with the page-pair number and address-space ID, the page mask, and both descriptors: bit 0 global, bit 1 valid, bit 2 dirty, bits 5:3 cache attribute, bits 25:6 frame, bit 30 execute-inhibit, bit 31 read-inhibit. The slot is chosen as in R3.
- R10: Reading an invalid entry loads the tag with 0x0000_0400 and the page mask and both descriptors with zero.
- R11: Command 5 invalidates every non-global entry whose address-space ID equals the tag's; global entries and other address spaces are kept.
- R12: Command 6 invalidates every entry.
- R13: The index register changes only through a register write to it or a probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Command code (1..6) |
| rand_idx | input | RAND_W | Pseudo-random slot for command 2 |
| reg_we | input | 1 | Staging register write enable |
| reg_sel | input | 3 | Staging register select (0..4) |
| reg_wdata | input | 32 | Staging register write data |
| entry_hi | output | 32 | Tag register |
| entry_lo0 | output | 32 | Even-page descriptor register |
| entry_lo1 | output | 32 | Odd-page descriptor register |
| page_mask | output | 32 | Page-size mask register |
| index_reg | output | 32 | Slot index register |

## Verification
The probe is driven from a table of tags against a preloaded array that holds a duplicated mapping, a global mapping, a large-page mapping, a slot marked invalid by the tag flag, and a slot whose global bit was only half set. The table tells lowest-slot priority apart from last-match, mask-covered bits apart from exact compares, and the global bypass apart from the address-space compare. Reads then confirm field packing, frame masking and the cleared pattern. The index register is preset to a nonzero value before each probe, so a miss that lost the low bits, or a hit that never wrote back, shows up. Directed runs cover slot selection modulo the entry count, random-slot writes, and both invalidation scopes through probes that must still hit or now miss.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;

    localparam int WORD_W    = 32;
    localparam int VPN2_W    = 19;
    localparam int VPN2_LSB  = 13;
    localparam int ASID_W    = 8;
    localparam int EHINV_BIT = 10;
    localparam int MASK_W    = 16;
    localparam int MASK_LSB  = 13;
    localparam int PFN_W     = 20;
    localparam int PFN_LSB   = 6;
    localparam int CATTR_W   = 3;
    localparam int CATTR_LSB = 3;
    localparam int XI_BIT    = 30;
    localparam int RI_BIT    = 31;
    localparam int MISS_BIT  = 31;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_WR_IDX   = 3'd1,
        OP_WR_RAND  = 3'd2,
        OP_PROBE    = 3'd3,
        OP_READ     = 3'd4,
        OP_INV_ASID = 3'd5,
        OP_INV_ALL  = 3'd6,
        OP_RSVD     = 3'd7
    } tlb_op_e;

    typedef enum logic [2:0] {
        SEL_HI    = 3'd0,
        SEL_LO0   = 3'd1,
        SEL_LO1   = 3'd2,
        SEL_MASK  = 3'd3,
        SEL_INDEX = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic               v;
        logic               d;
        logic [CATTR_W-1:0] cattr;
        logic               xi;
        logic               ri;
        logic [PFN_W-1:0]   pfn;
    } tlb_half_t;

    typedef struct packed {
        logic                inv;
        logic                g;
        logic [VPN2_W-1:0]   vpn2;
        logic [ASID_W-1:0]   asid;
        logic [MASK_W-1:0]   mask;
        tlb_half_t [1:0]     half;
    } tlb_entry_t;

    // Unpack one descriptor word; frame bits under the page mask are dropped.
    function automatic tlb_half_t lo_to_half(input logic [WORD_W-1:0] lo,
                                             input logic [MASK_W-1:0] m);
        tlb_half_t h;
        h.v     = lo[1];
        h.d     = lo[2];
        h.cattr = lo[CATTR_LSB +: CATTR_W];
        h.xi    = lo[XI_BIT];
        h.ri    = lo[RI_BIT];
        h.pfn   = lo[PFN_LSB +: PFN_W] & ~PFN_W'(m);
        return h;
    endfunction

    function automatic logic [WORD_W-1:0] half_to_lo(input tlb_half_t h, input logic g);
        logic [WORD_W-1:0] lo;
        lo = '0;
        lo[0] = g;
        lo[1] = h.v;
        lo[2] = h.d;
        lo[CATTR_LSB +: CATTR_W] = h.cattr;
        lo[PFN_LSB +: PFN_W] = h.pfn;
        lo[XI_BIT] = h.xi;
        lo[RI_BIT] = h.ri;
        return lo;
    endfunction

    function automatic tlb_entry_t build_entry(input logic [WORD_W-1:0] hi,
                                               input logic [WORD_W-1:0] lo0,
                                               input logic [WORD_W-1:0] lo1,
                                               input logic [WORD_W-1:0] pm);
        tlb_entry_t e;
        e.inv     = hi[EHINV_BIT];
        e.g       = lo0[0] & lo1[0];
        e.vpn2    = hi[VPN2_LSB +: VPN2_W];
        e.asid    = hi[ASID_W-1:0];
        e.mask    = pm[MASK_LSB +: MASK_W];
        e.half[0] = lo_to_half(lo0, e.mask);
        e.half[1] = lo_to_half(lo1, e.mask);
        return e;
    endfunction

    function automatic logic [WORD_W-1:0] tag_word(input tlb_entry_t e);
        logic [WORD_W-1:0] w;
        w = '0;
        w[VPN2_LSB +: VPN2_W] = e.vpn2;
        w[ASID_W-1:0] = e.asid;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] mask_word(input logic [MASK_W-1:0] m);
        logic [WORD_W-1:0] w;
        w = '0;
        w[MASK_LSB +: MASK_W] = m;
        return w;
    endfunction

endpackage

// File: rtl/soft_tlb_store.sv
module soft_tlb_store
    import soft_tlb_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  tlb_entry_t                   wr_entry,
    input  logic                         inv_asid_en,
    input  logic                         inv_all_en,
    input  logic [ASID_W-1:0]            cur_asid,
    output tlb_entry_t [N_ENTRIES-1:0]   entries
);

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
        tlb_entry_t slot_q;
        logic       sel;
        logic       asid_kill;

        assign sel       = wr_en && (wr_idx == IDX_W'(i));
        assign asid_kill = inv_asid_en && !slot_q.g && (slot_q.asid == cur_asid);

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q     <= '0;
                slot_q.inv <= 1'b1;
            end else if (inv_all_en || asid_kill) begin
                slot_q.inv <= 1'b1;
            end else if (sel) begin
                if (wr_entry.inv) begin
                    slot_q.inv <= 1'b1;
                end else begin
                    slot_q <= wr_entry;
                end
            end
        end

        assign entries[i] = slot_q;
    end

endmodule

// File: rtl/soft_tlb_match.sv
module soft_tlb_match
    import soft_tlb_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  tlb_entry_t [N_ENTRIES-1:0]   entries,
    input  logic [VPN2_W-1:0]            probe_vpn2,
    input  logic [ASID_W-1:0]            probe_asid,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);

    logic [N_ENTRIES-1:0] hit_vec;

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
        logic [VPN2_W-1:0] care;
        logic              tag_eq;
        logic              space_ok;

        assign care     = ~VPN2_W'(entries[i].mask);
        assign tag_eq   = ((entries[i].vpn2 ^ probe_vpn2) & care) == '0;
        assign space_ok = entries[i].g || (entries[i].asid == probe_asid);
        assign hit_vec[i] = !entries[i].inv && space_ok && tag_eq;
    end

    // Lowest slot wins: scan downward so the last assignment is the smallest.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
    import soft_tlb_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int RAND_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [RAND_W-1:0] rand_idx,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       entry_hi,
    output logic [31:0]       entry_lo0,
    output logic [31:0]       entry_lo1,
    output logic [31:0]       page_mask,
    output logic [31:0]       index_reg
);

    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

    tlb_op_e                   op;
    logic                      do_wr_idx, do_wr_rand, do_probe, do_read;
    logic                      do_inv_asid, do_inv_all;
    logic [IDX_W-1:0]          slot_from_index;
    logic [IDX_W-1:0]          slot_from_rand;
    logic [IDX_W-1:0]          wr_slot;
    tlb_entry_t                staged;
    tlb_entry_t [N_ENTRIES-1:0] entries;
    tlb_entry_t                rd_entry;
    logic                      hit;
    logic [IDX_W-1:0]          hit_idx;

    assign op          = tlb_op_e'(cmd_op);
    assign do_wr_idx   = cmd_valid && (op == OP_WR_IDX);
    assign do_wr_rand  = cmd_valid && (op == OP_WR_RAND);
    assign do_probe    = cmd_valid && (op == OP_PROBE);
    assign do_read     = cmd_valid && (op == OP_READ);
    assign do_inv_asid = cmd_valid && (op == OP_INV_ASID);
    assign do_inv_all  = cmd_valid && (op == OP_INV_ALL);

    assign slot_from_index = IDX_W'(index_reg[30:0] % N_ENTRIES);
    assign slot_from_rand  = IDX_W'(rand_idx % N_ENTRIES);
    assign wr_slot         = do_wr_rand ? slot_from_rand : slot_from_index;
    assign staged          = build_entry(entry_hi, entry_lo0, entry_lo1, page_mask);
    assign rd_entry        = entries[slot_from_index];

    soft_tlb_store #(.N_ENTRIES(N_ENTRIES)) u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (do_wr_idx || do_wr_rand),
        .wr_idx      (wr_slot),
        .wr_entry    (staged),
        .inv_asid_en (do_inv_asid),
        .inv_all_en  (do_inv_all),
        .cur_asid    (entry_hi[ASID_W-1:0]),
        .entries     (entries)
    );

    soft_tlb_match #(.N_ENTRIES(N_ENTRIES)) u_match (
        .entries    (entries),
        .probe_vpn2 (entry_hi[VPN2_LSB +: VPN2_W]),
        .probe_asid (entry_hi[ASID_W-1:0]),
        .hit        (hit),
        .hit_idx    (hit_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_hi  <= '0;
            entry_lo0 <= '0;
            entry_lo1 <= '0;
            page_mask <= '0;
            index_reg <= '0;
        end else begin
            if (reg_we) begin
                case (reg_sel_e'(reg_sel))
                    SEL_HI:    entry_hi  <= reg_wdata;
                    SEL_LO0:   entry_lo0 <= reg_wdata;
                    SEL_LO1:   entry_lo1 <= reg_wdata;
                    SEL_MASK:  page_mask <= reg_wdata;
                    SEL_INDEX: index_reg <= reg_wdata;
                    default:   ;
                endcase
            end
            // Command results take precedence over a same-cycle register write.
            if (do_probe) begin
                if (hit) begin
                    index_reg <= WORD_W'(hit_idx);
                end else begin
                    index_reg[MISS_BIT] <= 1'b1;
                    index_reg[30:0]     <= index_reg[30:0];
                end
            end
            if (do_read) begin
                if (rd_entry.inv) begin
                    entry_hi  <= WORD_W'(1) << EHINV_BIT;
                    page_mask <= '0;
                    entry_lo0 <= '0;
                    entry_lo1 <= '0;
                end else begin
                    entry_hi  <= tag_word(rd_entry);
                    page_mask <= mask_word(rd_entry.mask);
                    entry_lo0 <= half_to_lo(rd_entry.half[0], rd_entry.g);
                    entry_lo1 <= half_to_lo(rd_entry.half[1], rd_entry.g);
                end
            end
        end
    end

endmodule

// File: rtl/soft_tlb_chk.sv
module soft_tlb_chk
    import soft_tlb_pkg::*;
#(
    parameter int N_ENTRIES = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [2:0]  cmd_op,
    input logic        reg_we,
    input logic [2:0]  reg_sel,
    input logic [31:0] entry_hi,
    input logic [31:0] entry_lo0,
    input logic [31:0] entry_lo1,
    input logic [31:0] page_mask,
    input logic [31:0] index_reg
);

    logic is_probe, is_read, is_inv_all, idx_written;
    assign is_probe    = cmd_valid && (cmd_op == OP_PROBE);
    assign is_read     = cmd_valid && (cmd_op == OP_READ);
    assign is_inv_all  = cmd_valid && (cmd_op == OP_INV_ALL);
    assign idx_written = reg_we && (reg_sel == SEL_INDEX);

    // R7
    probe_hit_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        is_probe |=> (index_reg[31] || (index_reg[30:0] < 31'(N_ENTRIES))));

    // R8
    probe_after_flush_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (is_probe && $past(is_inv_all)) |=> index_reg[31]);

    // R10
    read_invalid_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        is_read |=> (!entry_hi[EHINV_BIT] ||
                     (entry_hi == 32'h0000_0400 && page_mask == '0 &&
                      entry_lo0 == '0 && entry_lo1 == '0)));

    // R4
    read_global_pair_chk: assert property (@(posedge clk) disable iff (rst)
        is_read |=> (entry_lo0[0] == entry_lo1[0]));

    // R9
    read_mask_field_chk: assert property (@(posedge clk) disable iff (rst)
        is_read |=> ((page_mask & ~32'h1FFF_E000) == '0));

    // R6
    read_pfn_masked_chk: assert property (@(posedge clk) disable iff (rst)
        is_read |=> (((entry_lo0[21:6] | entry_lo1[21:6]) & page_mask[28:13]) == '0));

    // R13
    index_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!is_probe && !idx_written) |=> $stable(index_reg));

endmodule

bind soft_tlb soft_tlb_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .entry_hi  (entry_hi),
    .entry_lo0 (entry_lo0),
    .entry_lo1 (entry_lo1),
    .page_mask (page_mask),
    .index_reg (index_reg)
);

// File: tb/soft_tlb_bench.sv
`timescale 1ns/1ps
module soft_tlb_bench;
    import soft_tlb_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  rand_idx = 8'd0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] entry_hi, entry_lo0, entry_lo1, page_mask, index_reg;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    soft_tlb u_soft_tlb (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .rand_idx(rand_idx), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .entry_hi(entry_hi), .entry_lo0(entry_lo0),
        .entry_lo1(entry_lo1), .page_mask(page_mask), .index_reg(index_reg)
    );

    // Probe table: {tag, expected index}; index is preset to 7 before each.
    localparam logic [63:0] PROBE_VEC [10] = '{
        {32'h0002_0005, 32'h0000_0000},  // R7 lowest of slots 0 and 5
        {32'h0002_0006, 32'h8000_0007},  // R8 private, other space
        {32'h0004_0003, 32'h0000_0001},  // R7 global ignores space ID
        {32'h0021_A005, 32'h0000_0002},  // R7 inside large page
        {32'h0021_A006, 32'h8000_0007},  // R7 large page, other space
        {32'h0022_0005, 32'h8000_0007},  // R7 above masked bits
        {32'h0006_0009, 32'h0000_0004},  // R5 invalid slot 3 skipped
        {32'h0006_0005, 32'h8000_0007},  // R5 flagged write stayed invalid
        {32'h0002_2005, 32'h8000_0007},  // R7 exact compare, no mask
        {32'h000C_0002, 32'h8000_0007}   // R4 half-global slot is private
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic cmd(input tlb_op_e op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic stage(input logic [31:0] hi, input logic [31:0] lo0,
                         input logic [31:0] lo1, input logic [31:0] pm);
        wr_reg(SEL_HI, hi); wr_reg(SEL_LO0, lo0);
        wr_reg(SEL_LO1, lo1); wr_reg(SEL_MASK, pm);
    endtask

    task automatic put(input logic [31:0] idx, input logic [31:0] hi, input logic [31:0] lo0,
                       input logic [31:0] lo1, input logic [31:0] pm);
        stage(hi, lo0, lo1, pm);
        wr_reg(SEL_INDEX, idx);
        cmd(OP_WR_IDX);
    endtask

    task automatic probe(input logic [31:0] hi);
        wr_reg(SEL_INDEX, 32'd7);
        wr_reg(SEL_HI, hi);
        cmd(OP_PROBE);
    endtask

    task automatic rd(input logic [31:0] idx);
        wr_reg(SEL_INDEX, idx);
        cmd(OP_READ);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 index", index_reg, 32'h0);
        chk("R1 tag", entry_hi, 32'h0);
        rd(32'd0);
        chk("R1 slot 0 invalid", entry_hi, 32'h0000_0400);

        // R2 register write port
        wr_reg(SEL_LO0, 32'h1234_5678);
        chk("R2 even descriptor", entry_lo0, 32'h1234_5678);

        put(32'd0, 32'h0002_0005, 32'h0000_48DE, 32'h0001_1582, 32'h0);
        put(32'd1, 32'h0004_0007, 32'h0000_0003, 32'h0000_0001, 32'h0);
        put(32'd2, 32'h0020_0005, 32'h02AF_37C2, 32'h0,         32'h0001_E000);
        put(32'd3, 32'h0006_0405, 32'h0000_0002, 32'h0,         32'h0);
        put(32'd4, 32'h0006_0009, 32'hC000_0042, 32'h0,         32'h0);
        put(32'd5, 32'h0002_0005, 32'h0000_0002, 32'h0,         32'h0);
        put(32'd6, 32'h000C_0001, 32'h0000_0003, 32'h0000_0002, 32'h0);

        for (int i = 0; i < 10; i++) begin
            probe(PROBE_VEC[i][63:32]);
            chk($sformatf("R7/R8 probe vector %0d", i), index_reg, PROBE_VEC[i][31:0]);
        end

        // R9 field packing
        rd(32'd0);
        chk("R9 tag", entry_hi, 32'h0002_0005);
        chk("R9 even", entry_lo0, 32'h0000_48DE);
        chk("R9 odd", entry_lo1, 32'h0001_1582);
        chk("R9 mask", page_mask, 32'h0);
        rd(32'd4);
        chk("R9 inhibit bits", entry_lo0, 32'hC000_0042);
        // R6 frame masked by page size
        rd(32'd2);
        chk("R6 frame", entry_lo0, 32'h02AF_3402);
        chk("R6 mask", page_mask, 32'h0001_E000);
        // R4 global bit
        rd(32'd1);
        chk("R4 global even", entry_lo0, 32'h0000_0003);
        chk("R4 global odd", entry_lo1, 32'h0000_0001);
        rd(32'd6);
        chk("R4 half set even", entry_lo0, 32'h0000_0002);
        // R10 invalid pattern
        rd(32'd3);
        chk("R10 tag", entry_hi, 32'h0000_0400);
        chk("R10 descriptors", entry_lo0 | entry_lo1 | page_mask, 32'h0);
        // R3 modulo slot selection
        rd(32'd10);
        chk("R3 index modulo", entry_hi, 32'h0020_0005);
        rd(32'h8000_0001);
        chk("R3 miss bit ignored", entry_hi, 32'h0004_0007);
        stage(32'h000E_0003, 32'h0000_0002, 32'h0, 32'h0);
        rand_idx = 8'd15;
        cmd(OP_WR_RAND);
        probe(32'h000E_0003);
        chk("R3 random slot", index_reg, 32'h0000_0007);

        // R13 index untouched by other commands
        wr_reg(SEL_INDEX, 32'h0000_0005);
        cmd(OP_READ);
        chk("R13 hold", index_reg, 32'h0000_0005);

        // R11 invalidate by space ID 5
        wr_reg(SEL_HI, 32'h0000_0005);
        cmd(OP_INV_ASID);
        probe(32'h0002_0005);
        chk("R11 private gone", index_reg, 32'h8000_0007);
        probe(32'h0021_A005);
        chk("R11 large page gone", index_reg, 32'h8000_0007);
        probe(32'h0004_0005);
        chk("R11 global kept", index_reg, 32'h0000_0001);
        probe(32'h0006_0009);
        chk("R11 other space kept", index_reg, 32'h0000_0004);

        // R12 invalidate all
        cmd(OP_INV_ALL);
        probe(32'h0004_0003);
        chk("R12 global gone", index_reg, 32'h8000_0007);
        rd(32'd1);
        chk("R12 read invalid", entry_hi, 32'h0000_0400);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule